// File: doc/BRIEF.md
# I2C EEPROM Slave Command Engine

This block is the protocol controller of a serial EEPROM that answers as a single target on an I2C bus. A separate condition detector supplies one-cycle strobes for start, stop, SCL rising and SCL falling, together with the synchronized SDA level. The engine returns a registered open-drain enable: when it is high, SDA is pulled low. The engine recognises one select code. It loads a two-byte word address, collects write data in a page buffer, and serves current-address, random and sequential reads from a behavioural byte array through a registered read port.

A write is committed only by a stop that falls in the slot right after a data-byte acknowledge. The buffered bytes are then copied into the array during a fixed program interval. For that whole interval the engine ignores the bus. A master therefore polls for completion by sending the select code until it is acknowledged. A write-control input refuses data bytes but still lets select and address bytes through.

Top module: `ee_cmd_engine`

## Requirements
- R1: The select byte is sent MSB first and its upper seven bits must be 1010000. Bit 0 = 1 requests a read and bit 0 = 0 requests a write. On any other code the engine gives no acknowledge and ignores the bus until the next start.
- R2: After a write select, two address bytes follow, high byte first. Only the low ADDR_W bits are used (default 9), so higher bits have no effect.
- R3: For every received byte that the engine accepts, sda_oe is 1 during the ninth clock.
- R4: While wc_in is 1, select and address bytes are acknowledged, data bytes are not acknowledged, and no location changes. Reads work the same for either level of wc_in.
- R5: A write select with an address, followed by a repeated start and a read select, returns data starting at that address.
- R6: In a read, a master acknowledge (SDA 0 on the ninth clock) makes the engine send the next byte. A no-acknowledge makes it release SDA and ignore the bus until a start.
- R7: The address counter advances after each byte read and wraps from the last array address to 0. A current-address read (a read select with no address) continues from it.
- R8: During a page write, the low PAGE_W address bits advance per data byte and wrap within the page. The upper address bits stay fixed.
- R9: Buffered data is committed only by a stop that arrives directly after a data-byte acknowledge clock. A stop at any other bit position discards the data.
- R10: A start or repeated start in any state aborts the transfer, discards buffered write data, and returns to select-byte reception.
- R11: After a commit, for PROG_CYCLES clocks the engine ignores all traffic. During that time it does not acknowledge its own select code.
- R12: sda_oe changes only in the cycle after an SCL falling strobe, or when a start, stop or program interval forces it to 0.
- R13: After reset, sda_oe is 0 and the engine waits for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | One-cycle strobe: start or repeated start seen |
| stop_det | input | 1 | One-cycle strobe: stop seen |
| scl_rise | input | 1 | One-cycle strobe: SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe: SCL falling edge |
| sda_in | input | 1 | Synchronized SDA level |
| wc_in | input | 1 | Write control: 1 refuses data bytes |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The hardest situation to reach is a stop that arrives inside a data byte rather than in the slot after its acknowledge. Accepted data is then sitting in the buffer but must not be committed. The bench reaches it by sending a fully acknowledged data byte, then three more bits, then a stop. It then reads the location back unchanged and finds the select acknowledged at once, with no program interval. A similar path checks a repeated start that follows an acknowledged data byte. The program interval is reached by polling immediately after a valid commit.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADRH, ST_ADRL, ST_WDATA, ST_RDATA
  } ee_state_e;
endpackage

// File: rtl/ee_array.sv
module ee_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq <= mem[raddr];
  end
endmodule

// File: rtl/ee_pagebuf.sv
module ee_pagebuf #(
  parameter int CW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [CW-1:0] wcol,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] rcol,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          any
);
  localparam int SLOTS = 1 << CW;
  logic [DW-1:0]    data [0:SLOTS-1];
  logic [SLOTS-1:0] valid;

  always_ff @(posedge clk) begin
    if (rst || clr) valid <= '0;
    else if (wr)    valid[wcol] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr) data[wcol] <= wdata;
  end

  assign rdata  = data[rcol];
  assign rvalid = valid[rcol];
  assign any    = |valid;

  // R10
  buf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ($countones(valid) == 0));
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 64,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic          scan_en,
  output logic [CW-1:0] scan_col
);
  localparam int TW = $clog2(CYCLES) + 1;
  localparam logic [TW-1:0] LAST   = TW'(CYCLES - 1);
  localparam logic [TW-1:0] SLOTS  = TW'(1 << CW);
  logic [TW-1:0] el;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      el   <= '0;
    end else if (go) begin
      busy <= 1'b1;
      el   <= '0;
    end else if (busy) begin
      el <= el + TW'(1);
      if (el == LAST) busy <= 1'b0;
    end
  end

  assign scan_en  = busy && (el < SLOTS);
  assign scan_col = el[CW-1:0];

  // R11
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
endmodule

// File: rtl/ee_cmd_engine.sv
module ee_cmd_engine #(
  parameter int         ADDR_W      = 9,
  parameter int         PAGE_W      = 4,
  parameter int         PROG_CYCLES = 64,
  parameter logic [6:0] DEV_ID      = 7'b1010000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  input  logic wc_in,
  output logic sda_oe
);
  import ee_pkg::*;

  localparam int ROW_W = ADDR_W - PAGE_W;

  ee_state_e         state;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx, hi;
  logic [ADDR_W-1:0] ptr;
  logic              ack_pend, oe;
  logic [7:0]        byte_in, rd_q, buf_rdata;
  logic [15:0]       addr16;
  logic              busy, go, buf_wr, buf_clr, buf_rvalid, buf_any, scan_en;
  logic [PAGE_W-1:0] scan_col;

  assign byte_in = {sh[6:0], sda_in};
  assign addr16  = {hi, sh};
  assign buf_wr  = !busy && !start_det && !stop_det && scl_rise &&
                   state == ST_WDATA && cnt == 4'd7 && !wc_in;
  assign buf_clr = start_det && !busy;
  assign go      = stop_det && !busy && !start_det && state == ST_WDATA &&
                   cnt == 4'd0 && buf_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      hi       <= '0;
      ptr      <= '0;
      ack_pend <= 1'b0;
      oe       <= 1'b0;
    end else if (busy) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (start_det) begin
      state <= ST_DEV;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (scl_rise && state != ST_IDLE) begin
      if (cnt != 4'd8) begin
        cnt <= cnt + 4'd1;
        if (state == ST_RDATA) tx <= {tx[6:0], 1'b0};
        else                   sh <= byte_in;
        if (cnt == 4'd7) begin
          unique case (state)
            ST_DEV:   ack_pend <= (byte_in[7:1] == DEV_ID);
            ST_ADRH,
            ST_ADRL:  ack_pend <= 1'b1;
            ST_WDATA: begin
              ack_pend <= !wc_in;
              if (!wc_in) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
            end
            default:  ack_pend <= 1'b0;
          endcase
        end
      end else begin
        cnt      <= '0;
        ack_pend <= 1'b0;
        unique case (state)
          ST_DEV: begin
            if (!ack_pend) state <= ST_IDLE;
            else if (sh[0]) begin
              state <= ST_RDATA;
              tx    <= rd_q;
              ptr   <= ptr + ADDR_W'(1);
            end else state <= ST_ADRH;
          end
          ST_ADRH: begin
            hi    <= sh;
            state <= ST_ADRL;
          end
          ST_ADRL: begin
            ptr   <= ADDR_W'(addr16);
            state <= ST_WDATA;
          end
          ST_RDATA: begin
            if (!sda_in) begin
              tx  <= rd_q;
              ptr <= ptr + ADDR_W'(1);
            end else state <= ST_IDLE;
          end
          default: state <= state;
        endcase
      end
    end else if (scl_fall) begin
      if (state == ST_RDATA) oe <= (cnt != 4'd8) && !tx[7];
      else oe <= (cnt == 4'd8) && ack_pend && (state != ST_IDLE);
    end
  end

  assign sda_oe = oe;

  ee_pagebuf #(.CW(PAGE_W), .DW(8)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr(buf_wr),
    .wcol(ptr[PAGE_W-1:0]), .wdata(byte_in), .rcol(scan_col),
    .rdata(buf_rdata), .rvalid(buf_rvalid), .any(buf_any)
  );

  ee_prog_timer #(.CYCLES(PROG_CYCLES), .CW(PAGE_W)) u_timer (
    .clk(clk), .rst(rst), .go(go), .busy(busy),
    .scan_en(scan_en), .scan_col(scan_col)
  );

  logic [ROW_W-1:0] row;
  assign row = ptr[ADDR_W-1:PAGE_W];

  ee_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(scan_en && buf_rvalid), .waddr({row, scan_col}),
    .wdata(buf_rdata), .raddr(ptr), .rq(rd_q)
  );

  // R12
  oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) ||
                          $past(stop_det) || $past(busy)));
  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);
  // R4
  wc_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_det && !stop_det && scl_rise && state == ST_WDATA &&
     cnt == 4'd7 && wc_in) |=> !ack_pend);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R1
  no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_det && !stop_det && scl_rise && state == ST_DEV &&
     cnt == 4'd8 && !ack_pend) |=> (state == ST_IDLE));
endmodule

// File: tb/ee_cmd_engine_bench.sv
module ee_cmd_engine_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic start_det = 0, stop_det = 0, scl_rise = 0, scl_fall = 0;
  logic sda_in = 1'b1, wc_in = 1'b0;
  logic sda_oe;
  int   total = 0, fails = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  ee_cmd_engine u_ee_cmd_engine (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .wc_in(wc_in), .sda_oe(sda_oe)
  );

  // {write address, read address, data}
  localparam logic [39:0] VEC [0:5] = '{
    40'h0003_0003_5A, 40'hFE10_0010_3C, 40'h01FF_01FF_A1,
    40'h0000_0000_B2, 40'h0001_0001_C3, 40'h0104_0104_96
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_in = b; tick(1);
    seen = sda_oe;
    scl_rise = 1; tick(1); scl_rise = 0; tick(1);
    scl_fall = 1; tick(1); scl_fall = 0; tick(1);
  endtask

  task automatic do_start();
    start_det = 1; tick(1); start_det = 0; tick(1);
  endtask

  task automatic do_stop();
    stop_det = 1; tick(1); stop_det = 0; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic o;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], o);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, o);
      d[i] = ~o;
    end
    clk_bit(!mack, o);
  endtask

  task automatic set_addr(input logic [15:0] a, output logic ad, output logic ah, output logic al);
    do_start();
    send_byte(8'hA0, ad);
    send_byte(a[15:8], ah);
    send_byte(a[7:0], al);
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] d);
    logic x, y, z, r;
    set_addr(a, x, y, z);
    do_start();
    send_byte(8'hA1, r);
    recv_byte(1'b0, d);
    do_stop();
  endtask

  task automatic wait_ready();
    logic a;
    for (int k = 0; k < 20; k++) begin
      do_start();
      send_byte(8'hA0, a);
      do_stop();
      if (a) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic ad, ah, al, ak, o;
    logic [7:0] d;
    tick(3); rst = 0; tick(2);
    // R13 reset state
    check(sda_oe == 1'b0, "R13", sda_oe, 0);

    // table walk: byte write, busy poll, random read
    for (int i = 0; i < 6; i++) begin
      set_addr(VEC[i][39:24], ad, ah, al);
      send_byte(VEC[i][7:0], ak);
      do_stop();
      check(ad && ah && al && ak, "R3", {ad, ah, al, ak}, 4'hF);
      do_start(); send_byte(8'hA0, o); do_stop();
      check(!o, "R11 busy poll", o, 0);
      wait_ready();
      read_at(VEC[i][23:8], d);
      check(d == VEC[i][7:0], "R2 R5 readback", d, VEC[i][7:0]);
    end

    // R1: wrong select codes
    do_start(); send_byte(8'hA2, o);
    check(!o, "R1 wrong code", o, 0);
    send_byte(8'h00, o);
    check(!o, "R1 ignored after mismatch", o, 0);
    do_stop();
    do_start(); send_byte(8'hB0, o); do_stop();
    check(!o, "R1 wrong id bit", o, 0);

    // R4: write control high
    wc_in = 1;
    set_addr(16'h0003, ad, ah, al);
    send_byte(8'h11, ak);
    do_stop();
    check(ad && ah && al, "R4 select/address acked", {ad, ah, al}, 3'h7);
    check(!ak, "R4 data refused", ak, 0);
    do_start(); send_byte(8'hA0, o); do_stop();
    check(o, "R4 no program cycle", o, 1);
    read_at(16'h0003, d);
    check(d == 8'h5A, "R4 unchanged, read with wc high", d, 8'h5A);
    wc_in = 0;

    // R10: repeated start discards buffered data
    set_addr(16'h0010, ad, ah, al);
    send_byte(8'h77, ak);
    do_start(); do_stop();
    do_start(); send_byte(8'hA0, o); do_stop();
    check(ak && o, "R10 no commit after restart", {ak, o}, 2'b11);
    read_at(16'h0010, d);
    check(d == 8'h3C, "R10 location kept", d, 8'h3C);

    // R9: stop inside a byte discards data
    set_addr(16'h0010, ad, ah, al);
    send_byte(8'h55, ak);
    clk_bit(1'b0, o); clk_bit(1'b1, o); clk_bit(1'b0, o);
    do_stop();
    do_start(); send_byte(8'hA0, o); do_stop();
    check(o, "R9 no program cycle", o, 1);
    read_at(16'h0010, d);
    check(d == 8'h3C, "R9 location kept", d, 8'h3C);

    // R8: page write wraps within the 16-byte page
    set_addr(16'h002C, ad, ah, al);
    for (int k = 0; k < 6; k++) send_byte(8'hD0 + 8'(k), ak);
    do_stop();
    wait_ready();
    set_addr(16'h0020, ad, ah, al);
    do_start(); send_byte(8'hA1, o);
    recv_byte(1'b1, d);
    check(d == 8'hD4, "R8 wrapped col 0", d, 8'hD4);
    recv_byte(1'b0, d);
    check(d == 8'hD5, "R8 wrapped col 1", d, 8'hD5);
    do_stop();
    set_addr(16'h002C, ad, ah, al);
    do_start(); send_byte(8'hA1, o);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, d);
      check(d == 8'hD0 + 8'(k), "R8 page body", d, 8'hD0 + 8'(k));
    end
    do_stop();

    // R7: sequential wrap at array end, then current-address read
    set_addr(16'h01FF, ad, ah, al);
    do_start(); send_byte(8'hA1, o);
    check(o, "R1 read select acked", o, 1);
    recv_byte(1'b1, d);
    check(d == 8'hA1, "R6 first byte", d, 8'hA1);
    recv_byte(1'b0, d);
    check(d == 8'hB2, "R7 wrap to zero", d, 8'hB2);
    do_stop();
    do_start(); send_byte(8'hA1, o);
    recv_byte(1'b0, d);
    check(d == 8'hC3, "R7 current address", d, 8'hC3);
    // R6: after no-acknowledge the bus is released
    send_byte(8'hA0, o);
    check(!o && !sda_oe, "R6 released after nack", o, 0);
    do_stop();

    // R12: acknowledge appears only after the falling strobe
    do_start();
    for (int i = 7; i >= 1; i--) clk_bit(8'hA0 >> i, o);
    sda_in = 0; tick(1);
    scl_rise = 1; tick(1); scl_rise = 0; tick(2);
    check(!sda_oe, "R12 held until SCL low", sda_oe, 0);
    scl_fall = 1; tick(1); scl_fall = 0; tick(1);
    check(sda_oe, "R12 ack after fall", sda_oe, 1);
    clk_bit(1'b1, o);
    do_stop();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule